// File: doc/BRIEF.md
# Multi-Port Receive Interface Scheduler

This block sits on the PHY side of a packet-over-SONET level-3 style receive interface. It faces several per-port receive FIFOs and one link. On each clock it decides whether to send an in-band port address, send a data word from the currently addressed port, or stay quiet. The FIFOs show the scheduler their fill level, whether a packet end is waiting, and their head word. The scheduler returns a one-hot pop when it takes that word.

The link throttles the transfer with an active-low read enable. A port becomes a candidate once its fill reaches a programmable threshold, or once it holds a complete packet end. Among the candidates, the choice rotates from the port after the current one.

Two modes are provided. In default mode the scheduler sticks with the current port for as long as it holds any data. In fixed-burst mode it pauses after every packet end before it picks again. While the link holds the enable inactive, it also keeps the address strobe raised with a frozen address.

Top module: `rx_port_sched`

## Requirements
- R1: After a synchronous active-low reset, `rdata`, `rvalid`, `rsx`, `rsop`, `reop`, `rmod` and `rerr` are 0 and `rparity` is 1.
- R2: A data word appears on the outputs (`rvalid`=1) only in the cycle after a clock edge at which `enb_n` was 0. The port's `port_pop` bit is high during the cycle before that edge.
- R3: `rsx` and `rvalid` are never high together. While `rsx` is high, `rdata[7:0]` holds the selected port number and `rdata[31:8]` is zero.
- R4: At most one `port_pop` bit is high in any cycle. Every word after an address strobe comes from the port that strobe named, in FIFO order, until the next strobe.
- R5: At most `BURST` words follow one strobe. The cycle after a word with `reop`=1, and the cycle after the `BURST`-th word, has `rvalid`=0.
- R6: In default mode (`fixed_burst`=0), after a burst or a packet end, the same port is strobed again if it holds any word or a pending packet end. Otherwise the next eligible port in rotation is chosen.
- R7: If `enb_n` is 1 at an edge while data is being sent, the next selection prefers any other eligible port, searched in rotation from the current port plus one. If no other port is eligible, the current port is taken again if it holds data. The new strobe comes at the next edge where `enb_n` is 0.
- R8: In fixed-burst mode, a word with `reop`=1 is followed by `PAUSE_CYC` cycles with `rvalid`=0 and `rsx`=0. Then a selection is made that prefers other eligible ports, falling back to the same port.
- R9: In fixed-burst mode, a selection made at an edge with `enb_n`=1 raises `rsx` and holds it high with an unchanged address until the first edge with `enb_n`=0. That edge gives one more strobe of the same address, and data then follows.
- R10: A port is eligible when its fill is nonzero and at least `fill_thresh`, or when its `port_eop_pend` bit is set. A port that is not eligible is never strobed, except as the current port under R6, R7 or R8.
- R11: `rparity` makes the 33 bits {`rdata`,`rparity`} hold an odd number of ones in every cycle. `rsop`, `reop` and `rerr` mirror the head word. `rmod` equals the head word's invalid-byte count on a word with `reop`=1, and is 0 otherwise.
- R12: If the addressed port is empty while `enb_n` is 0 during a burst, the cycle after has `rvalid`=0 and `rsx`=0 and no pop happens. Words resume from the same port without a new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fixed_burst | input | 1 | 1 selects fixed-burst mode, 0 default mode |
| fill_thresh | input | FILL_W | Fill level a port needs to become eligible |
| port_fill | input | NPORTS*FILL_W | Words held by each FIFO, port p in slice p |
| port_eop_pend | input | NPORTS | FIFO p holds a word marked end of packet |
| port_data | input | NPORTS*DATA_W | Head data word of each FIFO |
| port_sop | input | NPORTS | Head word starts a packet |
| port_eop | input | NPORTS | Head word ends a packet |
| port_mod | input | NPORTS*MW | Invalid bytes in the head word |
| port_err | input | NPORTS | Head word carries a packet error |
| enb_n | input | 1 | Active-low read enable from the link |
| port_pop | output | NPORTS | One-hot pop of the head word |
| rdata | output | DATA_W | Data word or in-band address |
| rvalid | output | 1 | Data outputs are meaningful |
| rsx | output | 1 | Start of transfer, address on rdata[7:0] |
| rsop | output | 1 | Start of packet |
| reop | output | 1 | End of packet |
| rmod | output | MW | Invalid bytes in the final word |
| rerr | output | 1 | Packet error |
| rparity | output | 1 | Odd parity over rdata |

## Verification
The bench builds the block with four ports, `BURST`=4 and `PAUSE_CYC`=2, and drives `fill_thresh` at 3. Four ports are enough for the rotation to wrap and to skip over ineligible ports. A burst of four splits a six-word packet into two strobes, so same-port reselection and an empty FIFO partway through a burst can both be reached. A threshold of three leaves a two-word fragment without a packet end ineligible until its end arrives. The pause of two cycles keeps the fixed-burst gaps short enough to be checked cycle by cycle.

// File: rtl/rx_port_sched_pkg.sv
// Shared types of the receive port scheduler.
// Assumes nothing beyond IEEE 1800-2017 enums.
package rx_port_sched_pkg;

    // Scheduler phase
    typedef enum logic [1:0] {
        ST_SEL   = 2'd0,
        ST_DATA  = 2'd1,
        ST_PAUSE = 2'd2,
        ST_HOLD  = 2'd3
    } sched_st_e;

    // What the output register loads on the coming edge
    typedef enum logic [1:0] {
        OUT_IDLE = 2'd0,
        OUT_ADDR = 2'd1,
        OUT_WORD = 2'd2
    } out_kind_e;

endpackage

// File: rtl/rxps_eligible.sv
// Per-port candidacy flags.
// A port is eligible when its nonzero fill reaches the threshold or a packet
// end is pending. A port "has data" when it holds any word or a pending end.
// Assumes the fill inputs are current for this cycle.
module rxps_eligible #(
    parameter int NPORTS = 4,
    parameter int FILL_W = 8
) (
    input  logic [NPORTS*FILL_W-1:0] port_fill,
    input  logic [NPORTS-1:0]        port_eop_pend,
    input  logic [FILL_W-1:0]        fill_thresh,
    output logic [NPORTS-1:0]        elig,
    output logic [NPORTS-1:0]        has_data
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [FILL_W-1:0] lvl;
        // Slice out this port's fill and derive its two flags
        always_comb begin
            lvl         = port_fill[p*FILL_W +: FILL_W];
            elig[p]     = ((lvl >= fill_thresh) && (lvl != '0)) || port_eop_pend[p];
            has_data[p] = (lvl != '0) || port_eop_pend[p];
        end
    end

endmodule

// File: rtl/rxps_rr_pick.sv
// Rotating first-requester search.
// Scans req starting at index start and wrapping around. It reports the first
// set bit. Assumes start < N.
module rxps_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Walk every position once in rotation order and keep the first hit
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int cand;
            cand = int'(start) + k;
            if (cand >= N) cand = cand - N;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/rxps_out_reg.sv
// Registered link-side outputs.
// Loads either an idle pattern, an in-band address or a data word on each
// edge, and computes odd parity over the value being loaded.
// Assumes kind is settled before the edge.
module rxps_out_reg
    import rx_port_sched_pkg::*;
#(
    parameter int IW     = 2,
    parameter int DATA_W = 32,
    parameter int MW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  out_kind_e         kind,
    input  logic [IW-1:0]     addr,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_sop,
    input  logic              w_eop,
    input  logic [MW-1:0]     w_mod,
    input  logic              w_err,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              rsx,
    output logic              rsop,
    output logic              reop,
    output logic [MW-1:0]     rmod,
    output logic              rerr,
    output logic              rparity
);

    logic [DATA_W-1:0] d_n;

    // Choose the value the data bus takes next
    always_comb begin
        case (kind)
            OUT_ADDR: d_n = DATA_W'(addr);
            OUT_WORD: d_n = w_data;
            default:  d_n = '0;
        endcase
    end

    // Register the bus, its qualifiers and its parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            rvalid  <= 1'b0;
            rsx     <= 1'b0;
            rsop    <= 1'b0;
            reop    <= 1'b0;
            rmod    <= '0;
            rerr    <= 1'b0;
            rparity <= 1'b1;
        end else begin
            rdata   <= d_n;
            rvalid  <= (kind == OUT_WORD);
            rsx     <= (kind == OUT_ADDR);
            rsop    <= (kind == OUT_WORD) && w_sop;
            reop    <= (kind == OUT_WORD) && w_eop;
            rmod    <= ((kind == OUT_WORD) && w_eop) ? w_mod : '0;
            rerr    <= (kind == OUT_WORD) && w_err;
            rparity <= ~^d_n;
        end
    end

    // R11: a nonzero modulo only ever comes with a valid end-of-packet word
    assert_mod_on_eop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rmod != '0) |-> (reop && rvalid));

    // R3: an address strobe and valid data never share a cycle
    assert_sx_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsx && rvalid));

endmodule

// File: rtl/rx_port_sched.sv
// Receive port scheduler, top level.
// Chooses a FIFO port, emits its in-band address strobe and then up to BURST
// words while the active-low enable allows. In default mode it reselects a
// port that still has data. In fixed-burst mode it pauses after a packet end
// and holds the strobe while the link is not ready.
// Assumes the FIFO head fields and fill levels are valid in the same cycle,
// and that a pop takes effect at the edge. Needs NPORTS <= 256 and
// PAUSE_CYC >= 1.
module rx_port_sched
    import rx_port_sched_pkg::*;
#(
    parameter int NPORTS    = 4,
    parameter int FILL_W    = 8,
    parameter int DATA_W    = 32,
    parameter int BURST     = 4,
    parameter int PAUSE_CYC = 2,
    localparam int IW = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int MW = $clog2(DATA_W/8)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fixed_burst,
    input  logic [FILL_W-1:0]        fill_thresh,
    input  logic [NPORTS*FILL_W-1:0] port_fill,
    input  logic [NPORTS-1:0]        port_eop_pend,
    input  logic [NPORTS*DATA_W-1:0] port_data,
    input  logic [NPORTS-1:0]        port_sop,
    input  logic [NPORTS-1:0]        port_eop,
    input  logic [NPORTS*MW-1:0]     port_mod,
    input  logic [NPORTS-1:0]        port_err,
    input  logic                     enb_n,
    output logic [NPORTS-1:0]        port_pop,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid,
    output logic                     rsx,
    output logic                     rsop,
    output logic                     reop,
    output logic [MW-1:0]            rmod,
    output logic                     rerr,
    output logic                     rparity
);

    localparam int BW = $clog2(BURST + 1);
    localparam int PW = $clog2(PAUSE_CYC + 1);

    sched_st_e         st, st_n;
    logic [IW-1:0]     cp, cp_n, addr_n, rr_start, other_idx, sel_idx;
    logic              pref, pref_n, other_ok, sel_ok, en;
    logic [BW-1:0]     bc, bc_n;
    logic [PW-1:0]     pc, pc_n;
    logic [NPORTS-1:0] elig, has_data, cp_oh;
    out_kind_e         kind;

    logic [FILL_W-1:0] fill_a [NPORTS];
    logic [DATA_W-1:0] data_a [NPORTS];
    logic [MW-1:0]     mod_a  [NPORTS];

    // Unpack the per-port buses into arrays
    for (genvar p = 0; p < NPORTS; p++) begin : g_unpack
        assign fill_a[p] = port_fill[p*FILL_W +: FILL_W];
        assign data_a[p] = port_data[p*DATA_W +: DATA_W];
        assign mod_a[p]  = port_mod[p*MW +: MW];
    end

    assign en = ~enb_n;

    rxps_eligible #(.NPORTS(NPORTS), .FILL_W(FILL_W)) i_elig (
        .port_fill     (port_fill),
        .port_eop_pend (port_eop_pend),
        .fill_thresh   (fill_thresh),
        .elig          (elig),
        .has_data      (has_data)
    );

    // One-hot of the current port and the rotation start after it
    always_comb begin
        cp_oh     = '0;
        cp_oh[cp] = 1'b1;
        rr_start  = (cp == IW'(NPORTS - 1)) ? '0 : cp + 1'b1;
    end

    rxps_rr_pick #(.N(NPORTS), .IW(IW)) i_pick (
        .req   (elig & ~cp_oh),
        .start (rr_start),
        .found (other_ok),
        .idx   (other_idx)
    );

    // Port choice: stay with the current port unless another one is preferred
    always_comb begin
        sel_ok  = 1'b1;
        sel_idx = cp;
        if (!pref && has_data[cp]) begin
            sel_idx = cp;
        end else if (other_ok) begin
            sel_idx = other_idx;
        end else if (has_data[cp]) begin
            sel_idx = cp;
        end else begin
            sel_ok = 1'b0;
        end
    end

    // Scheduler next state, pop and output load selection
    always_comb begin
        st_n     = st;
        cp_n     = cp;
        pref_n   = pref;
        bc_n     = bc;
        pc_n     = pc;
        kind     = OUT_IDLE;
        addr_n   = cp;
        port_pop = '0;
        case (st)
            ST_SEL: begin
                if (sel_ok && (en || fixed_burst)) begin
                    kind   = OUT_ADDR;
                    addr_n = sel_idx;
                    cp_n   = sel_idx;
                    bc_n   = '0;
                    st_n   = en ? ST_DATA : ST_HOLD;
                end
            end
            ST_HOLD: begin
                kind = OUT_ADDR;
                if (en) begin
                    st_n = ST_DATA;
                    bc_n = '0;
                end
            end
            ST_DATA: begin
                if (!en) begin
                    st_n   = ST_SEL;
                    pref_n = 1'b1;
                end else if (fill_a[cp] != '0) begin
                    kind         = OUT_WORD;
                    port_pop[cp] = 1'b1;
                    if (port_eop[cp]) begin
                        if (fixed_burst) begin
                            st_n = ST_PAUSE;
                            pc_n = PW'(PAUSE_CYC);
                        end else begin
                            st_n   = ST_SEL;
                            pref_n = 1'b0;
                        end
                    end else if (bc == BW'(BURST - 1)) begin
                        st_n   = ST_SEL;
                        pref_n = 1'b0;
                    end else begin
                        bc_n = bc + 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (pc <= PW'(1)) begin
                    st_n   = ST_SEL;
                    pref_n = 1'b1;
                end else begin
                    pc_n = pc - 1'b1;
                end
            end
            default: st_n = ST_SEL;
        endcase
    end

    // Scheduler state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_SEL;
            cp   <= '0;
            pref <= 1'b0;
            bc   <= '0;
            pc   <= '0;
        end else begin
            st   <= st_n;
            cp   <= cp_n;
            pref <= pref_n;
            bc   <= bc_n;
            pc   <= pc_n;
        end
    end

    rxps_out_reg #(.IW(IW), .DATA_W(DATA_W), .MW(MW)) i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .addr    (addr_n),
        .w_data  (data_a[cp]),
        .w_sop   (port_sop[cp]),
        .w_eop   (port_eop[cp]),
        .w_mod   (mod_a[cp]),
        .w_err   (port_err[cp]),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .rsx     (rsx),
        .rsop    (rsop),
        .reop    (reop),
        .rmod    (rmod),
        .rerr    (rerr),
        .rparity (rparity)
    );

    // Monitor: valid words seen on the outputs since the last strobe
    logic [BW:0] mon_words;
    always_ff @(posedge clk) begin
        if (!rst_n)                                      mon_words <= '0;
        else if (rsx)                                    mon_words <= '0;
        else if (rvalid && (mon_words != {(BW+1){1'b1}})) mon_words <= mon_words + 1'b1;
    end

    // R2: valid data only after an edge that saw the enable active
    assert_valid_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!enb_n));

    // R2: a pop is always followed by a valid word
    assert_pop_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_pop != '0) |=> rvalid);

    // R4: never more than one FIFO popped at a time
    assert_pop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_pop));

    // R5: a strobe is followed by at most BURST words
    assert_burst_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mon_words <= (BW+1)'(BURST));

    // R5: valid drops right after a packet end
    assert_gap_after_eop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && reop) |=> !rvalid);

    // R8: the pause after a packet end stays quiet
    assert_pause_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAUSE) |=> (!rvalid && !rsx));

    // R9: back-to-back strobes keep the same address
    assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsx && $past(rsx)) |-> $stable(rdata));

    // R12: an empty addressed FIFO yields an idle cycle
    assert_empty_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DATA) && en && (fill_a[cp] == '0)) |=> (!rvalid && !rsx));

endmodule

// File: tb/test_rx_port_sched.sv
// Bench for the receive port scheduler: FIFO queues and a behavioural
// reference model, compared against the design on every clock.
module test_rx_port_sched;

    localparam int NP = 4, FW = 8, DW = 32, BURST = 4, PAUSE_CYC = 2, MW = 2;

    typedef struct packed {
        logic [31:0] d;
        logic        sop;
        logic        eop;
        logic [1:0]  m;
        logic        err;
    } wd_t;

    logic clk = 1'b0, rst_n = 1'b0, fixed_burst = 1'b0, enb_n = 1'b1;
    logic [FW-1:0]    fill_thresh = 8'd3;
    logic [NP*FW-1:0] port_fill = '0;
    logic [NP-1:0]    port_eop_pend = '0, port_sop = '0, port_eop = '0, port_err = '0;
    logic [NP*DW-1:0] port_data = '0;
    logic [NP*MW-1:0] port_mod = '0;
    logic [NP-1:0]    port_pop;
    logic [DW-1:0]    rdata;
    logic             rvalid, rsx, rsop, reop, rerr, rparity;
    logic [MW-1:0]    rmod;

    always #10 clk = ~clk;

    rx_port_sched #(.NPORTS(NP), .FILL_W(FW), .DATA_W(DW), .BURST(BURST),
                    .PAUSE_CYC(PAUSE_CYC)) i_rx_port_sched (
        .clk(clk), .rst_n(rst_n), .fixed_burst(fixed_burst), .fill_thresh(fill_thresh),
        .port_fill(port_fill), .port_eop_pend(port_eop_pend), .port_data(port_data),
        .port_sop(port_sop), .port_eop(port_eop), .port_mod(port_mod), .port_err(port_err),
        .enb_n(enb_n), .port_pop(port_pop), .rdata(rdata), .rvalid(rvalid), .rsx(rsx),
        .rsop(rsop), .reop(reop), .rmod(rmod), .rerr(rerr), .rparity(rparity));

    int tests = 0, fails = 0, pkt_no = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    wd_t fq [NP][$];

    // model state: 0 select, 1 data, 2 pause, 3 hold
    int m_state = 0, m_cp = 0, m_bc = 0, m_pc = 0;
    bit m_pref = 1'b0;
    logic [NP-1:0] m_pop = '0;
    logic [38:0]   exp_v = {32'h0, 6'b0, 1'b1};

    function automatic int fill_of(int p);
        return fq[p].size();
    endfunction

    function automatic bit eop_pend_of(int p);
        for (int i = 0; i < fq[p].size(); i++) if (fq[p][i].eop) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [38:0] pack_out(logic [31:0] d, bit v, bit sx, bit so,
                                             bit eo, logic [1:0] m, bit er);
        return {d, v, sx, so, eo, m, er, ~^d};
    endfunction

    // Put the head of every queue onto the FIFO-side inputs
    task automatic drive_inputs();
        for (int p = 0; p < NP; p++) begin
            port_fill[p*FW +: FW] = FW'(fill_of(p));
            port_eop_pend[p]      = eop_pend_of(p);
            if (fq[p].size() > 0) begin
                port_data[p*DW +: DW] = fq[p][0].d;
                port_sop[p]           = fq[p][0].sop;
                port_eop[p]           = fq[p][0].eop;
                port_mod[p*MW +: MW]  = fq[p][0].m;
                port_err[p]           = fq[p][0].err;
            end else begin
                port_data[p*DW +: DW] = '0;
                port_sop[p] = 1'b0; port_eop[p] = 1'b0;
                port_mod[p*MW +: MW] = '0; port_err[p] = 1'b0;
            end
        end
    endtask

    // Port choice per R6, R7, R10
    task automatic m_pick(output bit ok, output int s);
        bit has_cp, other;
        int o;
        has_cp = (fill_of(m_cp) > 0) || eop_pend_of(m_cp);
        other = 1'b0; o = 0;
        for (int k = 1; k < NP; k++) begin
            int c;
            c = (m_cp + k) % NP;
            if (!other && (((fill_of(c) >= int'(fill_thresh)) && fill_of(c) > 0)
                           || eop_pend_of(c))) begin
                other = 1'b1; o = c;
            end
        end
        ok = 1'b1;
        if (!m_pref && has_cp) s = m_cp;
        else if (other) s = o;
        else if (has_cp) s = m_cp;
        else begin ok = 1'b0; s = m_cp; end
    endtask

    // One clock of the reference model, using the inputs just driven
    task automatic model_step();
        bit e, ok;
        int s;
        e = !enb_n;
        m_pop = '0;
        exp_v = pack_out(32'h0, 0, 0, 0, 0, 2'b0, 0);
        case (m_state)
            0: begin
                m_pick(ok, s);
                if (ok && (e || fixed_burst)) begin
                    exp_v = pack_out(32'(s), 0, 1, 0, 0, 2'b0, 0);
                    m_cp = s; m_bc = 0;
                    m_state = e ? 1 : 3;
                end
            end
            3: begin
                exp_v = pack_out(32'(m_cp), 0, 1, 0, 0, 2'b0, 0);
                if (e) begin m_state = 1; m_bc = 0; end
            end
            1: begin
                if (!e) begin
                    m_state = 0; m_pref = 1'b1;
                end else if (fill_of(m_cp) > 0) begin
                    wd_t w;
                    w = fq[m_cp][0];
                    exp_v = pack_out(w.d, 1, 0, w.sop, w.eop, w.eop ? w.m : 2'b0, w.err);
                    m_pop[m_cp] = 1'b1;
                    if (w.eop) begin
                        if (fixed_burst) begin m_state = 2; m_pc = PAUSE_CYC; end
                        else begin m_state = 0; m_pref = 1'b0; end
                    end else if (m_bc == BURST - 1) begin
                        m_state = 0; m_pref = 1'b0;
                    end else m_bc++;
                end
            end
            default: begin
                if (m_pc <= 1) begin m_state = 0; m_pref = 1'b1; end
                else m_pc--;
            end
        endcase
    endtask

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            logic [38:0] act;
            drive_inputs();
            #1;
            model_step();
            check(port_pop === m_pop, cur_req, "pop (R4)", 64'(port_pop), 64'(m_pop));
            @(negedge clk);
            act = {rdata, rvalid, rsx, rsop, reop, rmod, rerr, rparity};
            check(act === exp_v, cur_req, "outputs", 64'(act), 64'(exp_v));
            check(rparity === ~^rdata, "R11", "parity", 64'(rparity), 64'(~^rdata));
            if (rsx)
                check(!rvalid && rdata[31:8] == 0, "R3", "strobe form",
                      64'({rvalid, rdata}), 64'(rdata[7:0]));
            for (int p = 0; p < NP; p++) if (m_pop[p]) void'(fq[p].pop_front());
        end
    endtask

    // Append n words to port p; sop on the first if asked, eop on the last if asked
    task automatic push_words(int p, int n, bit first_sop, bit last_eop, bit err);
        pkt_no++;
        for (int i = 0; i < n; i++) begin
            wd_t w;
            w.d   = {8'(p), 8'(pkt_no), 16'(i)} ^ 32'h3C00_A50F;
            w.sop = first_sop && (i == 0);
            w.eop = last_eop && (i == n - 1);
            w.m   = w.eop ? 2'(pkt_no) : 2'b0;
            w.err = w.eop && err;
            fq[p].push_back(w);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs after reset
        check({rdata, rvalid, rsx, rsop, reop, rmod, rerr, rparity} === {32'h0, 6'b0, 1'b1},
              "R1", "reset state", 64'({rdata, rvalid, rsx, rsop, reop, rmod, rerr, rparity}),
              64'({32'h0, 6'b0, 1'b1}));

        // R2 R5 R6: six-word packet split into two bursts on one port
        cur_req = "R6"; enb_n = 1'b0;
        push_words(1, 6, 1, 1, 0);
        tick(14);

        // R10: a short fragment stays ineligible until its end arrives
        cur_req = "R10";
        push_words(2, 2, 1, 0, 0);
        tick(5);
        push_words(3, 3, 1, 1, 1);
        tick(8);
        push_words(2, 1, 0, 1, 0);
        tick(8);

        // R12: the FIFO runs dry partway through a burst, then resumes
        cur_req = "R12";
        push_words(0, 3, 1, 0, 0);
        tick(7);
        push_words(0, 2, 0, 1, 0);
        tick(9);

        // R7: the enable is withdrawn mid-burst, another eligible port wins
        cur_req = "R7";
        push_words(1, 8, 1, 1, 0);
        push_words(3, 3, 1, 1, 0);
        tick(3);
        enb_n = 1'b1; tick(3);
        enb_n = 1'b0; tick(26);

        // R8: fixed-burst pause, then the same port again
        cur_req = "R8"; fixed_burst = 1'b1;
        push_words(2, 2, 1, 1, 0);
        push_words(2, 2, 1, 1, 1);
        tick(14);

        // R9: strobe held while the enable is inactive, then data
        cur_req = "R9";
        enb_n = 1'b1;
        push_words(0, 3, 1, 1, 0);
        tick(4);
        enb_n = 1'b0; tick(10);

        // R7 R9: withdrawal in fixed-burst mode raises a held strobe for another port
        cur_req = "R7";
        push_words(1, 6, 1, 1, 0);
        push_words(3, 3, 1, 1, 0);
        tick(3);
        enb_n = 1'b1; tick(4);
        enb_n = 1'b0; tick(30);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog %s: actual hung expected done", cur_req);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule